// File: doc/BRIEF.md
# Receive Buffer Credit and Pause Controller

This block keeps a running count of the receive buffers that software has handed to one receive DMA channel. Software raises the count by writing a number of freshly armed buffers. It can also overwrite the count outright, for example to clear it before a ring is set up. The receive engine pulses a strobe each time it fills a descriptor, and each pulse lowers the count by one.

The count is compared against two programmable thresholds, both measured in descriptors. A pause request toward the packet source rises when the count drops to the lower threshold. It falls only once the count has climbed back to the upper threshold, so the request does not chatter while the count hovers between the two. A typical setup puts the lower mark at one third of the ring and the upper mark at two thirds.

A global configuration word holds a master enable and one pause-enable bit per pair of channels. The pause request is held low unless both bits that apply to this channel are set.

Top module: `rxbuf_credit_ctrl`

## Requirements
- R1: After reset the available count is 0 and the pause request is low.
- R2: A write with `wr_sel`=3 and `wr_data[31]`=0 adds `wr_data[11:0]` to the count. The new count is visible on the cycle after the write.
- R3: A write with `wr_sel`=3 and `wr_data[31]`=1 loads the count with `wr_data[11:0]`. A consume strobe in the same cycle is ignored.
- R4: Each consume strobe lowers the count by one. At zero the count stays at zero.
- R5: An add and a consume in the same cycle are both applied: the count becomes count+amount-1.
- R6: The count is 12 bits wide and holds at 4095 instead of wrapping.
- R7: `wr_sel`=1 writes the lower threshold and `wr_sel`=2 writes the upper threshold, each from `wr_data[11:0]`. `wr_sel`=0 writes the configuration word.
- R8: With pause enabled, the pause request is high on the cycle after the registered count is less than or equal to the lower threshold.
- R9: With pause enabled, the pause request goes low on the cycle after the registered count is greater than or equal to the upper threshold. While the count lies strictly between the thresholds, the request keeps its previous value.
- R10: The pause request is forced low on the cycle after configuration bit 0 (master enable) or configuration bit ((CH_ID>>1)+1) is clear. No other configuration bit has any effect.
- R11: When both threshold conditions hold at once, the assert condition wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 config, 1 lower threshold, 2 upper threshold, 3 buffer allocation |
| wr_data | input | DATA_W | Write data; bit DATA_W-1 selects force-load on allocation writes |
| consume | input | 1 | One descriptor filled by the receive engine |
| avail_count | output | CNT_W | Registered available-buffer count |
| fc_req | output | 1 | Registered pause request |

## Verification
Directed sequences cover the count's edges and the pause hysteresis:
- Draining to zero and consuming again separates saturating from wrapping.
- Overflowing the count past 4095 separates clamping from wrapping.
- A force-load paired with a consume shows that the load has priority.
- Walking the count down through the lower mark and back up through the upper mark separates true hysteresis from a single-threshold compare.

Configuration words that set only the unrelated bits check that the gate decodes the right bits. Constrained random traffic uses small add amounts around random thresholds, so the count crosses both marks many times, with every register kind and coincident add/consume mixed in.

// File: rtl/rbfc_pkg.sv
package rbfc_pkg;
  typedef enum logic [1:0] {
    SEL_CFG   = 2'd0,
    SEL_LOW   = 2'd1,
    SEL_HIGH  = 2'd2,
    SEL_ALLOC = 2'd3
  } rbfc_sel_e;

  localparam int THR_LOW_IDX  = 0;
  localparam int THR_HIGH_IDX = 1;
  localparam int NUM_THR      = 2;
endpackage

// File: rtl/rbfc_regs.sv
module rbfc_regs
  import rbfc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int CFG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [CNT_W-1:0]  low_thr,
  output logic [CNT_W-1:0]  high_thr,
  output logic              alloc_add,
  output logic              alloc_force,
  output logic [CNT_W-1:0]  alloc_amt
);
  localparam int FORCE_BIT = DATA_W - 1;

  logic [CNT_W-1:0] thr_q [NUM_THR];
  logic             alloc_hit;

  // configuration word
  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (wr_en && wr_sel == SEL_CFG)
      cfg_q <= wr_data[CFG_W-1:0];
  end

  // one register per threshold, each decoded from its own select code
  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    localparam logic [1:0] MY_SEL = (t == THR_LOW_IDX) ? SEL_LOW : SEL_HIGH;
    always_ff @(posedge clk) begin
      if (rst)
        thr_q[t] <= '0;
      else if (wr_en && wr_sel == MY_SEL)
        thr_q[t] <= wr_data[CNT_W-1:0];
    end
  end

  assign low_thr  = thr_q[THR_LOW_IDX];
  assign high_thr = thr_q[THR_HIGH_IDX];

  assign alloc_hit   = wr_en && (wr_sel == SEL_ALLOC);
  assign alloc_force = alloc_hit && wr_data[FORCE_BIT];
  assign alloc_add   = alloc_hit && !wr_data[FORCE_BIT];
  assign alloc_amt   = wr_data[CNT_W-1:0];

  AST_THR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(low_thr) && $stable(high_thr) && $stable(cfg_q))); // R7
endmodule

// File: rtl/rbfc_credit_ctr.sv
module rbfc_credit_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_add,
  input  logic             alloc_force,
  input  logic [CNT_W-1:0] alloc_amt,
  input  logic             consume,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W:0] MAX_EXT = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W:0]   sum_ext;
  logic [CNT_W:0]   dec_ext;
  logic [CNT_W-1:0] next_cnt;

  always_comb begin
    sum_ext = {1'b0, count} + (alloc_add ? {1'b0, alloc_amt} : '0);
    dec_ext = (consume && sum_ext != '0) ? sum_ext - 1'b1 : sum_ext;
    if (alloc_force)
      next_cnt = alloc_amt;
    else if (dec_ext > MAX_EXT)
      next_cnt = MAX_EXT[CNT_W-1:0];
    else
      next_cnt = dec_ext[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= next_cnt;
  end

  AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (rst)
    alloc_force |=> count == $past(alloc_amt)); // R3
  AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !alloc_add && !alloc_force) |=> count == '0); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (count == MAX_EXT[CNT_W-1:0] && alloc_add && !consume && !alloc_force)
      |=> count == MAX_EXT[CNT_W-1:0]); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!alloc_add && !alloc_force && !consume) |=> $stable(count)); // R2
endmodule

// File: rtl/rbfc_hyst.sv
module rbfc_hyst #(
  parameter int CNT_W  = 12,
  parameter int CFG_W  = 5,
  parameter int EN_BIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_q,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] low_thr,
  input  logic [CNT_W-1:0] high_thr,
  output logic             fc_req
);
  logic gate_on;
  logic at_low;
  logic at_high;

  assign gate_on = cfg_q[0] && cfg_q[EN_BIT];
  assign at_low  = count <= low_thr;
  assign at_high = count >= high_thr;

  always_ff @(posedge clk) begin
    if (rst)          fc_req <= 1'b0;
    else if (!gate_on) fc_req <= 1'b0;
    else if (at_low)   fc_req <= 1'b1;
    else if (at_high)  fc_req <= 1'b0;
  end

  AST_FC_GATED: assert property (@(posedge clk) disable iff (rst)
    !(cfg_q[0] && cfg_q[EN_BIT]) |=> !fc_req); // R10
  AST_FC_RISE: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[0] && cfg_q[EN_BIT] && count <= low_thr) |=> fc_req); // R8
  AST_FC_BAND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[0] && cfg_q[EN_BIT] && count > low_thr && count < high_thr)
      |=> $stable(fc_req)); // R9
  AST_FC_FALL: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[0] && cfg_q[EN_BIT] && count > low_thr && count >= high_thr)
      |=> !fc_req); // R9
endmodule

// File: rtl/rxbuf_credit_ctrl.sv
module rxbuf_credit_ctrl
  import rbfc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int NUM_CH = 8,
  parameter int CH_ID  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              consume,
  output logic [CNT_W-1:0]  avail_count,
  output logic              fc_req
);
  localparam int CFG_W  = ((NUM_CH - 1) >> 1) + 2;
  localparam int EN_BIT = (CH_ID >> 1) + 1;

  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] low_thr;
  logic [CNT_W-1:0] high_thr;
  logic             alloc_add;
  logic             alloc_force;
  logic [CNT_W-1:0] alloc_amt;

  rbfc_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cfg_q(cfg_q), .low_thr(low_thr), .high_thr(high_thr),
    .alloc_add(alloc_add), .alloc_force(alloc_force), .alloc_amt(alloc_amt)
  );

  rbfc_credit_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .alloc_add(alloc_add), .alloc_force(alloc_force),
    .alloc_amt(alloc_amt), .consume(consume), .count(avail_count)
  );

  rbfc_hyst #(.CNT_W(CNT_W), .CFG_W(CFG_W), .EN_BIT(EN_BIT)) u_hyst (
    .clk(clk), .rst(rst), .cfg_q(cfg_q), .count(avail_count),
    .low_thr(low_thr), .high_thr(high_thr), .fc_req(fc_req)
  );

  initial begin
    AST_CH_RANGE: assert (CH_ID < NUM_CH && CNT_W < DATA_W); // R10
  end
endmodule

// File: tb/sim_rxbuf_credit_ctrl.sv
module sim_rxbuf_credit_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        consume = 1'b0;
  logic [11:0] avail_count;
  logic        fc_req;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // model state (channel 2: enable bit 2)
  int m_cnt = 0, m_low = 0, m_high = 0;
  bit [31:0] m_cfg = 0;
  bit m_fc = 0;

  always #5 clk = ~clk;

  rxbuf_credit_ctrl #(.CH_ID(2)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .consume(consume), .avail_count(avail_count), .fc_req(fc_req)
  );

  function automatic int cnt_next(int c, bit we, bit [1:0] sel, bit [31:0] d, bit cons);
    int s;
    if (we && sel == 2'd3 && d[31]) return int'(d[11:0]);
    s = c + ((we && sel == 2'd3) ? int'(d[11:0]) : 0);
    if (cons && s > 0) s = s - 1;
    if (s > 4095) s = 4095;
    return s;
  endfunction

  function automatic bit fc_next(bit fc, int c, int lo, int hi, bit [31:0] cfg);
    if (!(cfg[0] && cfg[2])) return 1'b0;
    if (c <= lo) return 1'b1;
    if (c >= hi) return 1'b0;
    return fc;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit we, bit [1:0] sel, bit [31:0] d, bit cons, string tag);
    bit nfc;
    int ncnt;
    wr_en = we; wr_sel = sel; wr_data = d; consume = cons;
    nfc  = fc_next(m_fc, m_cnt, m_low, m_high, m_cfg);
    ncnt = cnt_next(m_cnt, we, sel, d, cons);
    if (we && sel == 2'd0) m_cfg = d;
    if (we && sel == 2'd1) m_low = int'(d[11:0]);
    if (we && sel == 2'd2) m_high = int'(d[11:0]);
    m_fc = nfc; m_cnt = ncnt;
    @(posedge clk);
    @(negedge clk);
    check({tag, " count"}, int'(avail_count), m_cnt);
    check({tag, " fc_req"}, int'(fc_req), int'(m_fc));
  endtask

  task automatic idle(string tag);
    step(1'b0, 2'd0, 32'd0, 1'b0, tag);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset count", int'(avail_count), 0);
    check("R1 reset fc_req", int'(fc_req), 0);

    step(1, 2'd0, 32'h5, 0, "R10 enable");
    step(1, 2'd1, 32'd3, 0, "R7 low thr");
    step(1, 2'd2, 32'd8, 0, "R7 high thr");
    step(1, 2'd3, 32'd5, 0, "R2 add");
    step(1, 2'd3, 32'd2, 1, "R5 add+consume");
    step(1, 2'd3, 32'h8000_0FFF, 0, "R3 force max");
    step(1, 2'd3, 32'd10, 0, "R6 clamp");
    step(1, 2'd3, 32'd1, 1, "R6 clamp add+consume");
    step(1, 2'd3, 32'h8000_0002, 1, "R3 force ignores consume");
    step(0, 2'd0, 32'd0, 1, "R4 consume");
    step(0, 2'd0, 32'd0, 1, "R4 consume to zero");
    step(0, 2'd0, 32'd0, 1, "R4 floor at zero");
    idle("R8 assert at low");
    step(1, 2'd3, 32'd5, 0, "R9 into band");
    idle("R9 hold in band");
    step(1, 2'd3, 32'd3, 0, "R9 reach high");
    idle("R9 deassert");
    step(0, 2'd0, 32'd0, 1, "R9 band after fall");
    repeat (3) step(0, 2'd0, 32'd0, 1, "R9 hold low in band");
    step(0, 2'd0, 32'd0, 1, "R8 reach low");
    idle("R8 assert");
    step(1, 2'd0, 32'h1A, 0, "R10 other bits only");
    idle("R10 gated low");
    step(1, 2'd0, 32'h1, 0, "R10 master only");
    idle("R10 still gated");
    step(1, 2'd0, 32'h5, 0, "R10 re-enable");
    idle("R10 resumes");
    step(1, 2'd3, 32'h8000_0007, 0, "R11 set count");
    step(1, 2'd1, 32'd10, 0, "R11 low above");
    step(1, 2'd2, 32'd5, 0, "R11 high below");
    idle("R11 assert wins");
    idle("R11 stays");

    for (int i = 0; i < 4000; i++) begin
      bit [1:0]  sel;
      bit [31:0] d;
      bit we, cons;
      int r;
      r    = int'($urandom_range(0, 99));
      we   = (r < 45);
      sel  = 2'($urandom_range(0, 3));
      cons = ($urandom_range(0, 1) == 1);
      case (sel)
        2'd0: d = ($urandom_range(0, 3) != 0) ? 32'h5 : $urandom;
        2'd1: d = 32'($urandom_range(0, 30));
        2'd2: d = 32'($urandom_range(0, 40));
        default: d = ($urandom_range(0, 15) == 0)
                     ? (32'h8000_0000 | 32'($urandom_range(0, 4095)))
                     : 32'($urandom_range(0, 6));
      endcase
      step(we, sel, d, cons, "random R2 R4 R5 R8 R9");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule